// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block accepts configuration words for a pair of frequency-synthesis channels over a three-wire serial link: a data line, a shift clock and a load strobe. A 22-bit word is shifted in most significant bit first. A rising edge on the load strobe transfers the word into one of four holding registers. Each channel has a reference register (reference divide ratio, phase-detector polarity, charge-pump current and tri-state, monitor selects) and a counter register (swallow count, programmable divide count, prescaler modulus, power-down). The two bits shifted in last form a routing code that picks the destination.

All three serial inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and shift and load actions happen on rising edges detected on the synchronized levels. The decoded fields are driven as parallel outputs to the divider and phase-detector logic. Channel index 0 is the high band and index 1 is the low band.

Top module: `serial_cfg_loader`

## Requirements
- R1: Each rising edge of the serial clock shifts one data bit in, most significant bit first. The last bit shifted in is word bit 1 and the first is word bit 22.
- R2: A load-strobe rising edge copies the word into exactly one register. The code is word bit 1 / word bit 2: 0/0 gives low-band reference, 0/1 gives high-band reference, 1/0 gives low-band counter, and 1/1 gives high-band counter. The other three registers keep their values.
- R3: Reference word layout: bits 3..17 hold the reference ratio with bit 3 as LSB. Bit 18 is phase polarity, bit 19 selects high pump current, bit 20 tri-states the pump, bit 21 selects the lock monitor and bit 22 selects the frequency monitor.
- R4: Counter word layout: bits 3..9 hold the swallow count with bit 3 as LSB, and bits 10..20 hold the programmable count with bit 10 as LSB. Bit 21 selects the wide prescaler modulus and bit 22 is power-down.
- R5: The high band keeps swallow bits 3..8 (6 bits) and ignores bit 9. The low band keeps swallow bits 3..6 (4 bits) and ignores bits 7..9.
- R6: Words still load while a channel's power-down bit is set.
- R7: The serial clock may stay high across a load. Leaving it high adds no shift, and a later load with no new clock rise reloads the same word.
- R8: While reset is asserted, every output is zero.
- R9: A register output changes on the third system clock rising edge after the load strobe rises at the pin, and at no other time.
- R10: A falling edge of the serial clock does not shift, and a falling or steady-high load strobe does not load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_load_i | input | 1 | Load strobe |
| ref_div_o | output | 2x15 | Reference divide ratio per channel |
| pd_pol_o | output | 2 | Phase-detector polarity per channel |
| cp_hi_o | output | 2 | High charge-pump current per channel |
| cp_hiz_o | output | 2 | Charge-pump tri-state per channel |
| mon_lock_o | output | 2 | Lock monitor select per channel |
| mon_freq_o | output | 2 | Frequency monitor select per channel |
| prog_div_o | output | 2x11 | Programmable divide count per channel |
| swl_hi_o | output | 6 | High-band swallow count |
| swl_lo_o | output | 4 | Low-band swallow count |
| pre_wide_o | output | 2 | Wide prescaler modulus per channel |
| pwr_dn_o | output | 2 | Power-down per channel |

## Verification
The hardest situation to reach is a serial clock edge that falls while no bits are being sent, or that sits high across a load. Either one could silently shift the word by a position. The stimulus leaves the clock high after the final bit of a high-band reference word, loads it, then drops the clock and loads again. A spurious shift would turn the routing code into 0/0 and overwrite the low-band reference, which the bench sees at the ports. A further sequence shifts a whole word in while the strobe is held high, then releases the strobe, so that only a level or falling-edge load could change any register.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int WORD_W    = 22;
  localparam int SEL_W     = 2;
  localparam int PAY_W     = WORD_W - SEL_W;
  localparam int REF_W     = 15;
  localparam int PROG_W    = 11;
  localparam int SWL_FLD_W = 7;
  localparam int SWL_HI_W  = 6;
  localparam int SWL_LO_W  = 4;
  localparam int NCH       = 2;
  localparam int CH_HI     = 0;
  localparam int CH_LO     = 1;
  // offsets inside the payload (word bits 3..22)
  localparam int SWL_OFS   = 0;
  localparam int PROG_OFS  = SWL_OFS + SWL_FLD_W;
  localparam int PRE_OFS   = PROG_OFS + PROG_W;
  localparam int PD_OFS    = PRE_OFS + 1;

  // code = {word bit 2, word bit 1}
  typedef enum logic [SEL_W-1:0] {
    DST_REF_LO = 2'b00,
    DST_CNT_LO = 2'b01,
    DST_REF_HI = 2'b10,
    DST_CNT_HI = 2'b11
  } dst_e;

  typedef struct packed {
    logic             mon_freq;
    logic             mon_lock;
    logic             hiz;
    logic             cp_hi;
    logic             pol;
    logic [REF_W-1:0] ratio;
  } ref_t;
endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[i];
        s2_q <= s1_q;
      end
    end
    assign lvl_o[i] = s2_q;
  end
endmodule

// File: rtl/serial_cfg_edge.sv
module serial_cfg_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/serial_cfg_shift.sv
module serial_cfg_shift #(
  parameter int W = 22
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (en_i) word_q <= {word_q[W-2:0], bit_i};
  end
  assign word_o = word_q;
endmodule

// File: rtl/serial_cfg_chan.sv
module serial_cfg_chan
  import serial_cfg_pkg::*;
#(
  parameter int SWL_W = SWL_HI_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_ref_i,
  input  logic                    ld_cnt_i,
  input  logic [PAY_W-1:0]        payload_i,
  output ref_t                    ref_o,
  output logic [PROG_W-1:0]       prog_o,
  output logic [SWL_W-1:0]        swl_o,
  output logic                    pre_o,
  output logic                    pd_o
);
  ref_t              ref_q;
  logic [PROG_W-1:0] prog_q;
  logic [SWL_W-1:0]  swl_q;
  logic              pre_q, pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ref_q <= '0;
    else if (ld_ref_i) ref_q <= ref_t'(payload_i);
  end

  // unused upper swallow bits are dropped here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q <= '0;
      swl_q  <= '0;
      pre_q  <= 1'b0;
      pd_q   <= 1'b0;
    end else if (ld_cnt_i) begin
      prog_q <= payload_i[PROG_OFS +: PROG_W];
      swl_q  <= payload_i[SWL_OFS +: SWL_W];
      pre_q  <= payload_i[PRE_OFS];
      pd_q   <= payload_i[PD_OFS];
    end
  end

  assign ref_o  = ref_q;
  assign prog_o = prog_q;
  assign swl_o  = swl_q;
  assign pre_o  = pre_q;
  assign pd_o   = pd_q;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ser_data_i,
  input  logic                        ser_clk_i,
  input  logic                        ser_load_i,
  output logic [NCH-1:0][REF_W-1:0]   ref_div_o,
  output logic [NCH-1:0]              pd_pol_o,
  output logic [NCH-1:0]              cp_hi_o,
  output logic [NCH-1:0]              cp_hiz_o,
  output logic [NCH-1:0]              mon_lock_o,
  output logic [NCH-1:0]              mon_freq_o,
  output logic [NCH-1:0][PROG_W-1:0]  prog_div_o,
  output logic [SWL_HI_W-1:0]         swl_hi_o,
  output logic [SWL_LO_W-1:0]         swl_lo_o,
  output logic [NCH-1:0]              pre_wide_o,
  output logic [NCH-1:0]              pwr_dn_o
);
  logic [2:0]        lvl_w;   // 0 data, 1 clock, 2 load
  logic [1:0]        rise_w;  // 0 clock, 1 load
  logic [WORD_W-1:0] shreg_w;
  dst_e              dst_w;
  logic [NCH-1:0]    ld_ref_w, ld_cnt_w;

  serial_cfg_sync #(.N(3)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ser_load_i, ser_clk_i, ser_data_i}),
    .lvl_o   (lvl_w)
  );

  serial_cfg_edge #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_w[2:1]),
    .rise_o (rise_w)
  );

  serial_cfg_shift #(.W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rise_w[0]),
    .bit_i  (lvl_w[0]),
    .word_o (shreg_w)
  );

  assign dst_w = dst_e'(shreg_w[SEL_W-1:0]);

  assign ld_ref_w[CH_HI] = rise_w[1] && (dst_w == DST_REF_HI);
  assign ld_ref_w[CH_LO] = rise_w[1] && (dst_w == DST_REF_LO);
  assign ld_cnt_w[CH_HI] = rise_w[1] && (dst_w == DST_CNT_HI);
  assign ld_cnt_w[CH_LO] = rise_w[1] && (dst_w == DST_CNT_LO);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int SW = (ch == CH_HI) ? SWL_HI_W : SWL_LO_W;
    ref_t          ref_w;
    logic [SW-1:0] swl_w;

    serial_cfg_chan #(.SWL_W(SW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_ref_i  (ld_ref_w[ch]),
      .ld_cnt_i  (ld_cnt_w[ch]),
      .payload_i (shreg_w[WORD_W-1:SEL_W]),
      .ref_o     (ref_w),
      .prog_o    (prog_div_o[ch]),
      .swl_o     (swl_w),
      .pre_o     (pre_wide_o[ch]),
      .pd_o      (pwr_dn_o[ch])
    );

    assign ref_div_o[ch]  = ref_w.ratio;
    assign pd_pol_o[ch]   = ref_w.pol;
    assign cp_hi_o[ch]    = ref_w.cp_hi;
    assign cp_hiz_o[ch]   = ref_w.hiz;
    assign mon_lock_o[ch] = ref_w.mon_lock;
    assign mon_freq_o[ch] = ref_w.mon_freq;

    if (ch == CH_HI) begin : g_hi
      assign swl_hi_o = swl_w;
    end else begin : g_lo
      assign swl_lo_o = swl_w;
    end
  end
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk
  import serial_cfg_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [WORD_W-1:0]          shreg_i,
  input logic [1:0]                 rise_i,
  input logic                       data_lvl_i,
  input logic [NCH-1:0][REF_W-1:0]  ref_div_o,
  input logic [NCH-1:0]             pd_pol_o,
  input logic [NCH-1:0]             cp_hi_o,
  input logic [NCH-1:0]             cp_hiz_o,
  input logic [NCH-1:0]             mon_lock_o,
  input logic [NCH-1:0]             mon_freq_o,
  input logic [NCH-1:0][PROG_W-1:0] prog_div_o,
  input logic [SWL_HI_W-1:0]        swl_hi_o,
  input logic [SWL_LO_W-1:0]        swl_lo_o,
  input logic [NCH-1:0]             pre_wide_o,
  input logic [NCH-1:0]             pwr_dn_o
);
  logic [REF_W+4:0]  g_ref_hi, g_ref_lo;
  logic [PROG_W+SWL_HI_W+1:0] g_cnt_hi;
  logic [PROG_W+SWL_LO_W+1:0] g_cnt_lo;

  assign g_ref_hi = {ref_div_o[CH_HI], pd_pol_o[CH_HI], cp_hi_o[CH_HI],
                     cp_hiz_o[CH_HI], mon_lock_o[CH_HI], mon_freq_o[CH_HI]};
  assign g_ref_lo = {ref_div_o[CH_LO], pd_pol_o[CH_LO], cp_hi_o[CH_LO],
                     cp_hiz_o[CH_LO], mon_lock_o[CH_LO], mon_freq_o[CH_LO]};
  assign g_cnt_hi = {prog_div_o[CH_HI], swl_hi_o, pre_wide_o[CH_HI], pwr_dn_o[CH_HI]};
  assign g_cnt_lo = {prog_div_o[CH_LO], swl_lo_o, pre_wide_o[CH_LO], pwr_dn_o[CH_LO]};

  a_r1_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i[0] |=> shreg_i == {$past(shreg_i[WORD_W-2:0]), $past(data_lvl_i)});

  a_r10_no_shift_without_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i[0] |=> $stable(shreg_i));

  a_r2_single_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({g_ref_hi != $past(g_ref_hi), g_ref_lo != $past(g_ref_lo),
              g_cnt_hi != $past(g_cnt_hi), g_cnt_lo != $past(g_cnt_lo)}));

  a_r9_change_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({g_ref_hi, g_ref_lo, g_cnt_hi, g_cnt_lo} !=
     $past({g_ref_hi, g_ref_lo, g_cnt_hi, g_cnt_lo})) |-> $past(rise_i[1]));

  a_r4_cnt_hi_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i[1] && shreg_i[1:0] == 2'b11) |=>
      (prog_div_o[CH_HI] == $past(shreg_i[19:9])) && (pwr_dn_o[CH_HI] == $past(shreg_i[21])));

  a_r3_ref_lo_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i[1] && shreg_i[1:0] == 2'b00) |=> ref_div_o[CH_LO] == $past(shreg_i[16:2]));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_zero: assert ({g_ref_hi, g_ref_lo, g_cnt_hi, g_cnt_lo} == '0);
    end
  end
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shreg_i    (shreg_w),
  .rise_i     (rise_w),
  .data_lvl_i (lvl_w[0]),
  .ref_div_o  (ref_div_o),
  .pd_pol_o   (pd_pol_o),
  .cp_hi_o    (cp_hi_o),
  .cp_hiz_o   (cp_hiz_o),
  .mon_lock_o (mon_lock_o),
  .mon_freq_o (mon_freq_o),
  .prog_div_o (prog_div_o),
  .swl_hi_o   (swl_hi_o),
  .swl_lo_o   (swl_lo_o),
  .pre_wide_o (pre_wide_o),
  .pwr_dn_o   (pwr_dn_o)
);

// File: tb/sim_serial_cfg_loader.sv
module sim_serial_cfg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_load = 1'b0;
  logic [1:0][14:0] ref_div;
  logic [1:0][10:0] prog_div;
  logic [1:0] pd_pol, cp_hi, cp_hiz, mon_lock, mon_freq, pre_wide, pwr_dn;
  logic [5:0] swl_hi;
  logic [3:0] swl_lo;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_cfg_loader u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ser_data_i(ser_data), .ser_clk_i(ser_clk), .ser_load_i(ser_load),
    .ref_div_o(ref_div), .pd_pol_o(pd_pol), .cp_hi_o(cp_hi), .cp_hiz_o(cp_hiz),
    .mon_lock_o(mon_lock), .mon_freq_o(mon_freq), .prog_div_o(prog_div),
    .swl_hi_o(swl_hi), .swl_lo_o(swl_lo), .pre_wide_o(pre_wide), .pwr_dn_o(pwr_dn)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit q[$];
  logic [3:0] h_d = '0, h_c = '0, h_l = '0;
  int m_ratio[2], m_pol[2], m_cp[2], m_hiz[2], m_lock[2], m_freq[2];
  int m_prog[2], m_pre[2], m_pd[2], m_swl_hi, m_swl_lo;

  initial begin
    for (int i = 0; i < 22; i++) q.push_back(1'b0);
    for (int c = 0; c < 2; c++) begin
      m_ratio[c] = 0; m_pol[c] = 0; m_cp[c] = 0; m_hiz[c] = 0; m_lock[c] = 0;
      m_freq[c] = 0; m_prog[c] = 0; m_pre[c] = 0; m_pd[c] = 0;
    end
    m_swl_hi = 0; m_swl_lo = 0;
  end

  task automatic model_load();
    logic [22:1] w;
    int c;
    for (int k = 1; k <= 22; k++) w[k] = q[22-k];
    c = w[2] ? 0 : 1;  // ref: bit2=1 high band; counter: bit2=1 high band
    if (!w[1]) begin
      m_ratio[c] = int'(w[17:3]); m_pol[c] = w[18]; m_cp[c] = w[19];
      m_hiz[c] = w[20]; m_lock[c] = w[21]; m_freq[c] = w[22];
    end else begin
      m_prog[c] = int'(w[20:10]); m_pre[c] = w[21]; m_pd[c] = w[22];
      if (c == 0) m_swl_hi = int'(w[8:3]);
      else        m_swl_lo = int'(w[6:3]);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      h_d = {h_d[2:0], ser_data};
      h_c = {h_c[2:0], ser_clk};
      h_l = {h_l[2:0], ser_load};
      if (h_l[2] && !h_l[3]) model_load();
      if (h_c[2] && !h_c[3]) begin
        q.push_back(h_d[2]);
        void'(q.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 2; c++) begin
        chk("R3 model ratio", int'(ref_div[c]), m_ratio[c]);
        chk("R3 model flags", int'({pd_pol[c], cp_hi[c], cp_hiz[c], mon_lock[c], mon_freq[c]}),
            int'({m_pol[c][0], m_cp[c][0], m_hiz[c][0], m_lock[c][0], m_freq[c][0]}));
        chk("R4 model counter", int'({prog_div[c], pre_wide[c], pwr_dn[c]}),
            int'({m_prog[c][10:0], m_pre[c][0], m_pd[c][0]}));
      end
      chk("R5 model swallow", int'({swl_hi, swl_lo}), int'({m_swl_hi[5:0], m_swl_lo[3:0]}));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(logic [22:1] w, bit hold_high);
    for (int k = 22; k >= 1; k--) begin
      ser_data = w[k];
      tick(3);
      ser_clk = 1'b1;
      tick(3);
      if (!(k == 1 && hold_high)) ser_clk = 1'b0;
      tick(2);
    end
  endtask

  task automatic pulse_load();
    ser_load = 1'b1;
    tick(4);
    ser_load = 1'b0;
    tick(6);
  endtask

  function automatic logic [22:1] ref_word(int ch, int ratio, bit pol, bit cp, bit hiz, bit lk, bit fq);
    logic [22:1] w;
    w[1] = 1'b0; w[2] = (ch == 0);
    w[17:3] = ratio[14:0];
    w[18] = pol; w[19] = cp; w[20] = hiz; w[21] = lk; w[22] = fq;
    return w;
  endfunction

  function automatic logic [22:1] cnt_word(int ch, int a, int b, bit pre, bit pd);
    logic [22:1] w;
    w[1] = 1'b1; w[2] = (ch == 0);
    w[9:3] = a[6:0]; w[20:10] = b[10:0];
    w[21] = pre; w[22] = pd;
    return w;
  endfunction

  initial begin
    tick(3);
    chk("R8 reset outputs", int'({ref_div, prog_div, swl_hi, swl_lo}), 0);
    chk("R8 reset flags", int'({pd_pol, cp_hi, cp_hiz, mon_lock, mon_freq, pre_wide, pwr_dn}), 0);
    rst_n = 1'b1;
    tick(2);

    // R3 R1: high-band reference
    shift_word(ref_word(0, 3, 1, 0, 1, 0, 1), 0);
    pulse_load();
    chk("R3 hi ratio", int'(ref_div[0]), 3);
    chk("R3 hi flags", int'({pd_pol[0], cp_hi[0], cp_hiz[0], mon_lock[0], mon_freq[0]}), 5'b10101);
    chk("R2 lo ref untouched", int'(ref_div[1]), 0);

    // R2: low-band reference, high band keeps value
    shift_word(ref_word(1, 32767, 0, 1, 0, 1, 1), 0);
    pulse_load();
    chk("R3 lo ratio", int'(ref_div[1]), 32767);
    chk("R3 lo flags", int'({pd_pol[1], cp_hi[1], cp_hiz[1], mon_lock[1], mon_freq[1]}), 5'b01011);
    chk("R2 hi ref kept", int'(ref_div[0]), 3);

    // R4 R5: high-band counter with bit 9 set
    shift_word(cnt_word(0, 7'h7F, 2047, 1, 1), 0);
    pulse_load();
    chk("R4 hi prog", int'(prog_div[0]), 2047);
    chk("R5 hi swallow", int'(swl_hi), 63);
    chk("R4 hi pre/pd", int'({pre_wide[0], pwr_dn[0]}), 3);

    // R5: low-band counter drops bits 7..9
    shift_word(cnt_word(1, 7'h5A, 3, 0, 1), 0);
    pulse_load();
    chk("R5 lo swallow", int'(swl_lo), 4'hA);
    chk("R4 lo prog", int'(prog_div[1]), 3);
    chk("R2 hi counter kept", int'(prog_div[0]), 2047);

    // R6: loads accepted while powered down
    shift_word(ref_word(0, 16'h1234, 0, 1, 0, 1, 0), 0);
    pulse_load();
    chk("R6 load during power-down", int'(ref_div[0]), 16'h1234);
    shift_word(cnt_word(0, 5, 100, 0, 0), 0);
    pulse_load();
    chk("R6 counter load during power-down", int'({prog_div[0], swl_hi}), int'({11'd100, 6'd5}));

    // R9: latency of three system clock edges
    shift_word(ref_word(1, 1000, 0, 0, 0, 0, 0), 0);
    tick(4);
    ser_load = 1'b1;
    tick(2);
    chk("R9 not yet after two edges", int'(ref_div[1]), 32767);
    tick(1);
    chk("R9 updated after three edges", int'(ref_div[1]), 1000);
    tick(2);
    ser_load = 1'b0;
    tick(6);

    // R7 R10: clock held high across load, then falling edge
    shift_word(ref_word(0, 500, 1, 1, 1, 1, 1), 1);
    pulse_load();
    chk("R7 load with clock high", int'(ref_div[0]), 500);
    ser_clk = 1'b0;
    tick(6);
    pulse_load();
    chk("R10 falling clock no shift (lo ref)", int'(ref_div[1]), 1000);
    chk("R7 reload same word", int'(ref_div[0]), 500);

    // R10: word shifted with load held high, then released
    ser_load = 1'b1;
    tick(6);
    shift_word(cnt_word(1, 3, 77, 1, 0), 0);
    ser_load = 1'b0;
    tick(8);
    chk("R10 no load on level/fall", int'(prog_div[1]), 3);
    pulse_load();
    chk("R10 rising load afterwards", int'(prog_div[1]), 77);
    chk("R5 lo swallow afterwards", int'(swl_lo), 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule